// File: doc/BRIEF.md
# USB Endpoint IN-Token Responder

This block is the device-side decision and sequencing logic for a single USB endpoint when the host sends an IN token. It latches a per-endpoint handshake-select field and the data PID when the token arrives. From the mode and the transmit FIFO state it chooses one of four outcomes: stream a data packet, reply NAK, reply STALL, or stay silent. NRZI coding, bit stuffing, CRC generation and the DMA that fills the FIFO are handled by neighbouring blocks. This block only tells them when to start, when to append the CRC, and which handshake to send.

When a data packet is sent, the block waits for the host handshake. The wait is bounded by a bit-time counter whose limit is an input. An ACK inside the window produces a one-cycle done pulse. If the window closes without an ACK, a timeout flag is raised and the block returns to idle. The data PID is never toggled here. Software supplies it, and it is held constant for the whole transaction.

Top module: `usb_in_responder`

## Requirements
- R1: After reset every output is low, including `timeout_o`, and the block is ready to accept a token.
- R2: With the handshake-select field at 2'b11, an IN token produces exactly one `hs_send_o` pulse with `hs_is_stall_o`=1 two cycles after the token edge. No data is sent, whatever the FIFO holds.
- R3: With the field at 2'b10, an IN token produces one `hs_send_o` pulse with `hs_is_stall_o`=0 (NAK) two cycles after the token edge. No data is sent, even when the FIFO is full.
- R4: With the field at 2'b01, an IN token produces neither a handshake nor data, and the block is idle again to take the next token.
- R5: With the field at 2'b00 and an empty FIFO (level 0, last-byte flag clear), the token is answered with a NAK.
- R6: With the field at 2'b00, transmission starts when the FIFO level is at least `MIN_START` (default 4) or the last-byte flag is set. With 1 to 3 bytes and the flag clear, the block waits until one of these holds. `pkt_start_o` pulses in the first cycle that `tx_active_o` is high.
- R7: `pkt_pid_o` carries the value of `data_pid_i` sampled at the token and holds it throughout the packet.
- R8: An end-of-buffer indication without the last-in-packet flag keeps the packet streaming. With the flag set, `tx_active_o` drops and `crc_append_o` pulses for exactly one cycle.
- R9: An ACK received before the window closes gives a `done_o` pulse one cycle later, and `timeout_o` stays low.
- R10: With no ACK, `timeout_o` rises exactly `ack_window_i`+1 bit ticks after the first cycle of the wait, and the block returns to idle. The flag clears when the next data packet starts.
- R11: A token that arrives while a transaction is in progress is ignored: it causes no handshake and does not disturb the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_in_i | input | 1 | One-cycle strobe: IN token addressed to this endpoint |
| hs_mode_i | input | 2 | Handshake select: 00 normal, 01 ignore, 10 NAK, 11 STALL |
| data_pid_i | input | 1 | Data PID for the packet (0 = DATA0, 1 = DATA1) |
| fifo_level_i | input | LVL_W | Bytes currently held in the transmit FIFO |
| fifo_last_i | input | 1 | The FIFO holds the final byte of the packet |
| buf_end_i | input | 1 | End of the current buffer reached while streaming |
| last_in_pkt_i | input | 1 | The current buffer is the last one of the packet |
| bit_tick_i | input | 1 | One strobe per USB bit time |
| ack_rx_i | input | 1 | One-cycle strobe: ACK handshake received from host |
| ack_window_i | input | TMR_W | Handshake wait limit in bit times |
| hs_send_o | output | 1 | One-cycle request to send a handshake packet |
| hs_is_stall_o | output | 1 | Handshake type with `hs_send_o`: 1 STALL, 0 NAK |
| pkt_start_o | output | 1 | One-cycle pulse at the start of a data packet |
| pkt_pid_o | output | 1 | Data PID for the packet being sent |
| tx_active_o | output | 1 | Data bytes are being streamed |
| crc_append_o | output | 1 | One-cycle request to append the CRC |
| done_o | output | 1 | One-cycle pulse: packet acknowledged by host |
| timeout_o | output | 1 | Host failed to acknowledge the last data packet |

## Verification
Each result has a fixed latency that is counted from the token edge. Handshake pulses and the start of a packet appear two cycles after the token strobe. The CRC request appears one cycle after end-of-buffer with the last flag, done one cycle after the ACK strobe, and the timeout flag `ack_window_i`+1 ticks into the wait. The bench drives and samples on falling edges and checks each output in exactly its due cycle. It also checks the cycle just before, so that an off-by-one in the window counter or a state that is entered one cycle late is reported.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_IGNORE = 2'b01,
      MODE_NAK    = 2'b10,
      MODE_STALL  = 2'b11
   } hs_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECIDE,
      ST_SEND_HS,
      ST_WAIT_FILL,
      ST_SEND_DATA,
      ST_SEND_CRC,
      ST_WAIT_ACK,
      ST_DONE
   } rsp_state_e;

endpackage

// File: rtl/usb_in_start_gate.sv
module usb_in_start_gate #(
   parameter int LVL_W     = 8,
   parameter int MIN_START = 4
) (
   input  logic [LVL_W-1:0] level_i,
   input  logic             last_i,
   output logic             have_data_o,
   output logic             start_ok_o
);
   localparam logic [LVL_W-1:0] START_LVL = LVL_W'(MIN_START);

   generate
      if (MIN_START < 1 || MIN_START >= (1 << LVL_W)) begin : g_bad_min
         $error("MIN_START must be between 1 and the FIFO level range");
      end
   endgenerate

   assign have_data_o = (level_i != '0) || last_i;
   assign start_ok_o  = last_i || (level_i >= START_LVL);

   // R6
   always_comb begin
      start_implies_data_chk : assert (!start_ok_o || have_data_o);
   end
endmodule

// File: rtl/usb_in_ack_timer.sv
module usb_in_ack_timer #(
   parameter int TMR_W        = 6,
   parameter bit USE_BIT_TICK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             bit_tick_i,
   input  logic [TMR_W-1:0] window_i,
   output logic             expired_o
);
   logic [TMR_W-1:0] cnt_q;
   logic             step;

   generate
      if (TMR_W < 2) begin : g_bad_w
         $error("TMR_W must be at least 2");
      end
      if (USE_BIT_TICK) begin : g_tick
         assign step = bit_tick_i;
      end else begin : g_clk
         assign step = 1'b1;
      end
   endgenerate

   assign expired_o = (cnt_q >= window_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (clr_i)                      cnt_q <= '0;
      else if (run_i && step && !expired_o) cnt_q <= cnt_q + 1'b1;
   end

   // R10
   expiry_holds_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && expired_o && !clr_i && $stable(window_i)) |=> expired_o);
endmodule

// File: rtl/usb_in_responder.sv
module usb_in_responder
   import usb_in_pkg::*;
#(
   parameter int LVL_W        = 8,
   parameter int MIN_START    = 4,
   parameter int TMR_W        = 6,
   parameter bit USE_BIT_TICK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_in_i,
   input  logic [1:0]       hs_mode_i,
   input  logic             data_pid_i,
   input  logic [LVL_W-1:0] fifo_level_i,
   input  logic             fifo_last_i,
   input  logic             buf_end_i,
   input  logic             last_in_pkt_i,
   input  logic             bit_tick_i,
   input  logic             ack_rx_i,
   input  logic [TMR_W-1:0] ack_window_i,
   output logic             hs_send_o,
   output logic             hs_is_stall_o,
   output logic             pkt_start_o,
   output logic             pkt_pid_o,
   output logic             tx_active_o,
   output logic             crc_append_o,
   output logic             done_o,
   output logic             timeout_o
);
   rsp_state_e state_q, state_d;
   hs_mode_e   mode_q;
   logic       pid_q, stall_q, stall_d;
   logic       start_q, timeout_q;
   logic       have_data, start_ok, expired;
   logic       go_data;

   usb_in_start_gate #(.LVL_W(LVL_W), .MIN_START(MIN_START)) u_gate (
      .level_i     (fifo_level_i),
      .last_i      (fifo_last_i),
      .have_data_o (have_data),
      .start_ok_o  (start_ok)
   );

   usb_in_ack_timer #(.TMR_W(TMR_W), .USE_BIT_TICK(USE_BIT_TICK)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (state_q == ST_SEND_CRC),
      .run_i      (state_q == ST_WAIT_ACK),
      .bit_tick_i (bit_tick_i),
      .window_i   (ack_window_i),
      .expired_o  (expired)
   );

   always_comb begin
      state_d = state_q;
      stall_d = stall_q;
      go_data = 1'b0;
      unique case (state_q)
         ST_IDLE:      if (tok_in_i) state_d = ST_DECIDE;
         ST_DECIDE: begin
            unique case (mode_q)
               MODE_IGNORE: state_d = ST_IDLE;
               MODE_NAK:    begin state_d = ST_SEND_HS; stall_d = 1'b0; end
               MODE_STALL:  begin state_d = ST_SEND_HS; stall_d = 1'b1; end
               default: begin
                  if (!have_data) begin
                     state_d = ST_SEND_HS;
                     stall_d = 1'b0;
                  end else if (start_ok) begin
                     state_d = ST_SEND_DATA;
                     go_data = 1'b1;
                  end else begin
                     state_d = ST_WAIT_FILL;
                  end
               end
            endcase
         end
         ST_SEND_HS:   state_d = ST_IDLE;
         ST_WAIT_FILL: if (start_ok) begin
            state_d = ST_SEND_DATA;
            go_data = 1'b1;
         end
         ST_SEND_DATA: if (buf_end_i && last_in_pkt_i) state_d = ST_SEND_CRC;
         ST_SEND_CRC:  state_d = ST_WAIT_ACK;
         ST_WAIT_ACK: begin
            if (ack_rx_i)     state_d = ST_DONE;
            else if (expired) state_d = ST_IDLE;
         end
         ST_DONE:      state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mode_q    <= MODE_NORMAL;
         pid_q     <= 1'b0;
         stall_q   <= 1'b0;
         start_q   <= 1'b0;
         timeout_q <= 1'b0;
      end else begin
         state_q <= state_d;
         stall_q <= stall_d;
         start_q <= go_data;
         if (state_q == ST_IDLE && tok_in_i) begin
            mode_q <= hs_mode_e'(hs_mode_i);
            pid_q  <= data_pid_i;
         end
         if (go_data || (state_q == ST_WAIT_ACK && ack_rx_i))
            timeout_q <= 1'b0;
         else if (state_q == ST_WAIT_ACK && expired)
            timeout_q <= 1'b1;
      end
   end

   assign hs_send_o     = (state_q == ST_SEND_HS);
   assign hs_is_stall_o = hs_send_o && stall_q;
   assign pkt_start_o   = start_q;
   assign pkt_pid_o     = (state_q == ST_SEND_DATA) && pid_q;
   assign tx_active_o   = (state_q == ST_SEND_DATA);
   assign crc_append_o  = (state_q == ST_SEND_CRC);
   assign done_o        = (state_q == ST_DONE);
   assign timeout_o     = timeout_q;

   // R2
   hs_data_excl_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_send_o && tx_active_o));
   // R2
   hs_single_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
      hs_send_o |=> !hs_send_o);
   // R6
   start_with_data_chk : assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start_o |-> tx_active_o);
   // R8
   crc_after_data_chk : assert property (@(posedge clk) disable iff (!rst_n)
      crc_append_o |-> $past(tx_active_o) && !tx_active_o);
   // R9
   done_no_timeout_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !timeout_o);
   // R7
   pid_stable_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active_o && $past(tx_active_o)) |-> $stable(pkt_pid_o));
endmodule

// File: tb/usb_in_responder_tb.sv
module usb_in_responder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tok = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       pid = 1'b0;
   logic [7:0] level = 8'd0;
   logic       flast = 1'b0;
   logic       bend = 1'b0;
   logic       blast = 1'b0;
   logic       tick = 1'b1;
   logic       ack = 1'b0;
   logic       hs_send, hs_stall, pstart, ppid, txa, crc, done, tmo;

   int n_chk = 0;
   int n_bad = 0;
   bit summary_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_in_responder dut_i (
      .clk(clk), .rst_n(rst_n), .tok_in_i(tok), .hs_mode_i(mode),
      .data_pid_i(pid), .fifo_level_i(level), .fifo_last_i(flast),
      .buf_end_i(bend), .last_in_pkt_i(blast), .bit_tick_i(tick),
      .ack_rx_i(ack), .ack_window_i(6'(WIN)),
      .hs_send_o(hs_send), .hs_is_stall_o(hs_stall), .pkt_start_o(pstart),
      .pkt_pid_o(ppid), .tx_active_o(txa), .crc_append_o(crc),
      .done_o(done), .timeout_o(tmo)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic nclk();
      @(negedge clk);
   endtask

   // token pulse; returns at the negedge where state is the decide step
   task automatic token(input logic [1:0] m, input logic p);
      mode = m; pid = p; tok = 1'b1;
      nclk();
      tok = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 hs_send", hs_send, 0); chk("R1 tx_active", txa, 0);
      chk("R1 crc", crc, 0);         chk("R1 done", done, 0);
      chk("R1 timeout", tmo, 0);     chk("R1 pkt_start", pstart, 0);
   endtask

   task automatic t_stall();
      level = 8'd10; flast = 1'b1;
      token(2'b11, 1'b0);
      chk("R2 early", hs_send, 0);
      nclk();
      chk("R2 hs_send", hs_send, 1); chk("R2 stall", hs_stall, 1);
      chk("R2 no data", txa, 0);
      nclk();
      chk("R2 single pulse", hs_send, 0); chk("R2 still no data", txa, 0);
   endtask

   task automatic t_nak_mode();
      level = 8'd20; flast = 1'b1;
      token(2'b10, 1'b0);
      nclk();
      chk("R3 hs_send", hs_send, 1); chk("R3 nak", hs_stall, 0);
      chk("R3 no data", txa, 0);
      nclk();
      chk("R3 no data after", txa, 0);
   endtask

   task automatic t_ignore();
      level = 8'd20; flast = 1'b1;
      token(2'b01, 1'b0);
      for (int i = 0; i < 3; i++) begin
         nclk();
         chk("R4 no handshake", hs_send, 0); chk("R4 no data", txa, 0);
      end
      token(2'b11, 1'b0);
      nclk();
      chk("R4 idle again", hs_send, 1);
      nclk();
   endtask

   task automatic t_nak_empty();
      level = 8'd0; flast = 1'b0;
      token(2'b00, 1'b0);
      nclk();
      chk("R5 nak on empty", hs_send, 1); chk("R5 nak type", hs_stall, 0);
      chk("R5 no data", txa, 0);
      nclk();
   endtask

   // finishes a packet already streaming; ack or let it time out
   task automatic finish_pkt(input bit do_ack, input bit inject_tok);
      if (inject_tok) begin
         mode = 2'b11; tok = 1'b1;
         nclk(); tok = 1'b0;
         chk("R11 no handshake", hs_send, 0); chk("R11 still streaming", txa, 1);
         nclk();
         chk("R11 no handshake later", hs_send, 0);
      end
      bend = 1'b1; blast = 1'b0;
      nclk();
      bend = 1'b0;
      chk("R8 buffer end keeps streaming", txa, 1); chk("R8 no crc yet", crc, 0);
      bend = 1'b1; blast = 1'b1;
      nclk();
      bend = 1'b0; blast = 1'b0;
      chk("R8 crc pulse", crc, 1); chk("R8 tx stops", txa, 0);
      nclk();
      chk("R8 crc one cycle", crc, 0);
      if (do_ack) begin
         ack = 1'b1;
         nclk();
         ack = 1'b0;
         chk("R9 done", done, 1); chk("R9 no timeout", tmo, 0);
         nclk();
         chk("R9 done one cycle", done, 0); chk("R9 timeout low", tmo, 0);
      end else begin
         repeat (WIN) nclk();
         chk("R10 not yet", tmo, 0);
         nclk();
         chk("R10 timeout set", tmo, 1); chk("R10 no done", done, 0);
      end
      if (inject_tok) chk("R11 no handshake at end", hs_send, 0);
   endtask

   task automatic t_full_start_ack();
      level = 8'd4; flast = 1'b0;
      token(2'b00, 1'b1);
      nclk();
      chk("R6 start at threshold", pstart, 1); chk("R6 tx", txa, 1);
      chk("R7 pid", ppid, 1);
      nclk();
      chk("R6 start one cycle", pstart, 0); chk("R7 pid held", ppid, 1);
      finish_pkt(1'b1, 1'b0);
   endtask

   task automatic t_wait_fill_timeout();
      level = 8'd2; flast = 1'b0;
      token(2'b00, 1'b0);
      for (int i = 0; i < 3; i++) begin
         nclk();
         chk("R6 waits for fill", txa, 0); chk("R6 no handshake", hs_send, 0);
      end
      level = 8'd4;
      nclk();
      chk("R6 start after fill", pstart, 1); chk("R7 pid0", ppid, 0);
      nclk();
      finish_pkt(1'b0, 1'b0);
   endtask

   task automatic t_last_short_busy();
      level = 8'd1; flast = 1'b1;
      chk("R10 flag before next", tmo, 1);
      token(2'b00, 1'b1);
      nclk();
      chk("R6 short last start", pstart, 1); chk("R10 cleared on start", tmo, 0);
      nclk();
      finish_pkt(1'b1, 1'b1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!summary_done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary_done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      nclk(); nclk();
      t_reset();
      rst_n = 1'b1;
      nclk();
      t_reset();
      t_stall();
      t_nak_mode();
      t_ignore();
      t_nak_empty();
      t_full_start_ack();
      t_wait_fill_timeout();
      t_last_short_busy();
      repeat (3) nclk();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule